// File: doc/BRIEF.md
# Correctable Error Status and Reporting

This block keeps the correctable error status of a link controller that serves up to eight functions. Each function has its own 32-bit status register and its own mask. Error detectors elsewhere in the controller send single-cycle event pulses. Link-wide events are copied into the status of every function. Per-function events reach only their own function. Status bits are sticky. Software clears a bit by writing a 1 to it, from either the configuration port or the local management port.

Whenever a bit goes from 0 to 1 in a function whose mask bit for that error is 0, the block asks the transmit side to send one correctable error message. It does this with a request/acknowledge pair. One request covers every event that arrives before the acknowledge, so an error that sets the bit in all functions costs only one message. A debug emulation input changes writes of 1 so that they set bits instead of clearing them. Bits set this way report exactly like bits set by hardware.

Top module: `corr_err_report`

## Requirements
- R1: While `rst` is high, every status bit and `msg_req` are 0 at the next clock edge, and they stay 0 until an event or a write occurs.
- R2: Only bits 0, 6, 7, 8, 12, 13, 14 and 15 exist, giving the implemented mask 0x0000F1C1. Every other bit always reads 0. A write of all ones in emulation mode leaves each function at no more than 0xF1C1.
- R3: A pulse on a link-wide event sets its bit in every function at the next edge. The mapping is receiver error to bit 0, bad TLP to bit 6, bad DLLP to bit 7, replay rollover to bit 8, replay timeout to bit 12 and internal corrected error to bit 14.
- R4: `ev_advisory[f]` sets bit 13 and `ev_hdr_ovf[f]` sets bit 15 of function f only.
- R5: With emulation off, a configuration write to function `cfg_fn` clears each status bit whose data bit is 1. Data bits that are 0, and the other functions, are left unchanged. Without a write, no bit ever clears.
- R6: The local management port (`mgmt_we`, `mgmt_fn`, `mgmt_wdata`) clears bits by writing 1, in the same way as the configuration port.
- R7: The mask never changes which status bits are set. With every mask bit of a function at 1, events in that function raise no request.
- R8: `msg_req` rises at the edge where at least one bit goes from 0 to 1 while its mask bit is 0. An event on a bit that is already set raises no new request. A link-wide event that sets the bit in every function yields one request.
- R9: `msg_req` stays high until a cycle with `msg_ack` high, and it falls at the following edge. New unmasked bits that arrive while it is high merge into the same request. If a new bit sets in the same cycle as the acknowledge, the request stays high.
- R10: When a hardware event and a write-one clear hit the same bit in the same cycle, the bit ends up set.
- R11: A bad DLLP event does not set bit 7 when `ev_phy_flag` is high in the same cycle.
- R12: The client input `client_corr_in` sets bit 14 in every function.
- R13: While `emul_en` is high, writes of 1 from either port set the addressed implemented bits instead of clearing them. These bits raise requests under the same mask rule as hardware events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high cold reset; the only clear apart from writes |
| ev_rx_err | input | 1 | Link-wide receiver error pulse |
| ev_bad_tlp | input | 1 | Link-wide bad TLP pulse |
| ev_bad_dllp | input | 1 | Link-wide bad DLLP pulse |
| ev_phy_flag | input | 1 | Physical layer error on the same packet; suppresses bad DLLP |
| ev_replay_roll | input | 1 | Link-wide replay number rollover pulse |
| ev_replay_tmo | input | 1 | Link-wide replay timer timeout pulse |
| ev_int_corr | input | 1 | Link-wide internal corrected error pulse |
| client_corr_in | input | 1 | Client logic correctable error input |
| ev_advisory | input | NUM_FN | Per-function advisory non-fatal pulse |
| ev_hdr_ovf | input | NUM_FN | Per-function header log overflow pulse |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_fn | input | FN_W | Configuration write target function |
| cfg_wdata | input | 32 | Configuration write data |
| mgmt_we | input | 1 | Management write strobe |
| mgmt_fn | input | FN_W | Management write target function |
| mgmt_wdata | input | 32 | Management write data |
| fn_mask | input | NUM_FN*32 | Mask per function, function f at bits [32f+31:32f] |
| emul_en | input | 1 | Debug emulation enable |
| fn_status | output | NUM_FN*32 | Status per function, function f at bits [32f+31:32f] |
| msg_req | output | 1 | Request to send one correctable error message |
| msg_ack | input | 1 | Acknowledge from the transmit side |

## Verification
The assertions assume that the function numbers on both write ports are in range. They also assume that `msg_ack` comes only from the message sender, and that clearing is done only by writes. The stimulus keeps to these assumptions: it addresses only the instantiated functions, and it drives every input one time unit after a rising edge. Event patterns are otherwise unrestricted. The sweeps cover every combination of link-wide events with the physical-flag and client input. They also cover every combination of per-function events, and a write of each bit position through each port in both emulation states. This tests merged requests, set-versus-clear collisions and masked functions in all of those orderings.

// File: rtl/corr_err_pkg.sv
package corr_err_pkg;
  localparam int STS_W  = 32;
  localparam int B_RX   = 0;
  localparam int B_TLP  = 6;
  localparam int B_DLLP = 7;
  localparam int B_ROLL = 8;
  localparam int B_TMO  = 12;
  localparam int B_ADV  = 13;
  localparam int B_INT  = 14;
  localparam int B_HLO  = 15;

  typedef logic [STS_W-1:0] sts_t;

  localparam sts_t IMPL_BITS = (sts_t'(1) << B_RX)   | (sts_t'(1) << B_TLP)  |
                               (sts_t'(1) << B_DLLP) | (sts_t'(1) << B_ROLL) |
                               (sts_t'(1) << B_TMO)  | (sts_t'(1) << B_ADV)  |
                               (sts_t'(1) << B_INT)  | (sts_t'(1) << B_HLO);
endpackage

// File: rtl/corr_evt_fanout.sv
module corr_evt_fanout
  import corr_err_pkg::*;
#(
  parameter int NUM_FN = 4
) (
  input  logic              ev_rx_err,
  input  logic              ev_bad_tlp,
  input  logic              ev_bad_dllp,
  input  logic              ev_phy_flag,
  input  logic              ev_replay_roll,
  input  logic              ev_replay_tmo,
  input  logic              ev_int_corr,
  input  logic              client_corr_in,
  input  logic [NUM_FN-1:0] ev_advisory,
  input  logic [NUM_FN-1:0] ev_hdr_ovf,
  output sts_t [NUM_FN-1:0] hw_set
);
  sts_t link_set;

  // link-wide events form one vector shared by every function
  always_comb begin
    link_set         = '0;
    link_set[B_RX]   = ev_rx_err;
    link_set[B_TLP]  = ev_bad_tlp;
    link_set[B_DLLP] = ev_bad_dllp & ~ev_phy_flag;
    link_set[B_ROLL] = ev_replay_roll;
    link_set[B_TMO]  = ev_replay_tmo;
    link_set[B_INT]  = ev_int_corr | client_corr_in;
  end

  for (genvar f = 0; f < NUM_FN; f++) begin : g_fn
    always_comb begin
      hw_set[f]        = link_set;
      hw_set[f][B_ADV] = ev_advisory[f];
      hw_set[f][B_HLO] = ev_hdr_ovf[f];
    end
  end
endmodule

// File: rtl/corr_sts_fn.sv
module corr_sts_fn
  import corr_err_pkg::*;
#(
  parameter int FN_ID = 0,
  parameter int FN_W  = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  sts_t            hw_set,
  input  logic            cfg_we,
  input  logic [FN_W-1:0] cfg_fn,
  input  sts_t            cfg_wdata,
  input  logic            mgmt_we,
  input  logic [FN_W-1:0] mgmt_fn,
  input  sts_t            mgmt_wdata,
  input  logic            emul_en,
  input  sts_t            mask,
  output sts_t            sts,
  output logic            trig
);
  sts_t sts_q;
  sts_t wr_ones;
  sts_t set_v;
  sts_t clr_v;

  always_comb begin
    wr_ones = '0;
    if (cfg_we && cfg_fn == FN_W'(FN_ID))   wr_ones = wr_ones | cfg_wdata;
    if (mgmt_we && mgmt_fn == FN_W'(FN_ID)) wr_ones = wr_ones | mgmt_wdata;
    set_v = (hw_set | (emul_en ? wr_ones : '0)) & IMPL_BITS;
    clr_v = emul_en ? '0 : wr_ones;
    // only 0->1 transitions of unmasked bits ask for a message
    trig  = |(set_v & ~sts_q & ~mask);
  end

  always_ff @(posedge clk) begin
    if (rst) sts_q <= '0;
    else     sts_q <= set_v | (sts_q & ~clr_v);
  end

  assign sts = sts_q;
endmodule

// File: rtl/corr_msg_req.sv
module corr_msg_req #(
  parameter int NUM_FN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_FN-1:0] fn_trig,
  input  logic              msg_ack,
  output logic              msg_req
);
  always_ff @(posedge clk) begin
    if (rst) msg_req <= 1'b0;
    else     msg_req <= (|fn_trig) | (msg_req & ~msg_ack);
  end
endmodule

// File: rtl/corr_err_report.sv
module corr_err_report
  import corr_err_pkg::*;
#(
  parameter int NUM_FN = 4,
  localparam int FN_W  = (NUM_FN > 1) ? $clog2(NUM_FN) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ev_rx_err,
  input  logic                    ev_bad_tlp,
  input  logic                    ev_bad_dllp,
  input  logic                    ev_phy_flag,
  input  logic                    ev_replay_roll,
  input  logic                    ev_replay_tmo,
  input  logic                    ev_int_corr,
  input  logic                    client_corr_in,
  input  logic [NUM_FN-1:0]       ev_advisory,
  input  logic [NUM_FN-1:0]       ev_hdr_ovf,
  input  logic                    cfg_we,
  input  logic [FN_W-1:0]         cfg_fn,
  input  logic [31:0]             cfg_wdata,
  input  logic                    mgmt_we,
  input  logic [FN_W-1:0]         mgmt_fn,
  input  logic [31:0]             mgmt_wdata,
  input  logic [NUM_FN*32-1:0]    fn_mask,
  input  logic                    emul_en,
  output logic [NUM_FN*32-1:0]    fn_status,
  output logic                    msg_req,
  input  logic                    msg_ack
);
  sts_t [NUM_FN-1:0] hw_set;
  sts_t [NUM_FN-1:0] sts_arr;
  logic [NUM_FN-1:0] trig_vec;

  corr_evt_fanout #(.NUM_FN(NUM_FN)) u_fanout (
    .ev_rx_err     (ev_rx_err),
    .ev_bad_tlp    (ev_bad_tlp),
    .ev_bad_dllp   (ev_bad_dllp),
    .ev_phy_flag   (ev_phy_flag),
    .ev_replay_roll(ev_replay_roll),
    .ev_replay_tmo (ev_replay_tmo),
    .ev_int_corr   (ev_int_corr),
    .client_corr_in(client_corr_in),
    .ev_advisory   (ev_advisory),
    .ev_hdr_ovf    (ev_hdr_ovf),
    .hw_set        (hw_set)
  );

  for (genvar f = 0; f < NUM_FN; f++) begin : g_fn
    corr_sts_fn #(.FN_ID(f), .FN_W(FN_W)) u_sts (
      .clk       (clk),
      .rst       (rst),
      .hw_set    (hw_set[f]),
      .cfg_we    (cfg_we),
      .cfg_fn    (cfg_fn),
      .cfg_wdata (cfg_wdata),
      .mgmt_we   (mgmt_we),
      .mgmt_fn   (mgmt_fn),
      .mgmt_wdata(mgmt_wdata),
      .emul_en   (emul_en),
      .mask      (fn_mask[f*STS_W +: STS_W]),
      .sts       (sts_arr[f]),
      .trig      (trig_vec[f])
    );
    assign fn_status[f*STS_W +: STS_W] = sts_arr[f];
  end

  corr_msg_req #(.NUM_FN(NUM_FN)) u_req (
    .clk    (clk),
    .rst    (rst),
    .fn_trig(trig_vec),
    .msg_ack(msg_ack),
    .msg_req(msg_req)
  );
endmodule

// File: rtl/corr_err_report_chk.sv
module corr_err_report_chk
  import corr_err_pkg::*;
#(
  parameter int NUM_FN = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 ev_rx_err,
  input logic                 client_corr_in,
  input logic                 cfg_we,
  input logic                 mgmt_we,
  input logic [NUM_FN*32-1:0] fn_status,
  input logic                 msg_req,
  input logic                 msg_ack
);
  logic [NUM_FN-1:0] col_rx;
  logic [NUM_FN-1:0] col_int;

  always_comb begin
    for (int f = 0; f < NUM_FN; f++) begin
      col_rx[f]  = fn_status[f*STS_W + B_RX];
      col_int[f] = fn_status[f*STS_W + B_INT];
    end
  end

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (fn_status & ~{NUM_FN{IMPL_BITS}}) == '0);

  assert_link_fanout_R3: assert property (@(posedge clk) disable iff (rst)
    ev_rx_err |=> &col_rx);

  assert_only_write_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (!cfg_we && !mgmt_we) |=> (($past(fn_status) & ~fn_status) == '0));

  assert_req_has_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(msg_req) |-> (fn_status != $past(fn_status)));

  assert_req_held_R9: assert property (@(posedge clk) disable iff (rst)
    (msg_req && !msg_ack) |=> msg_req);

  assert_client_pin_R12: assert property (@(posedge clk) disable iff (rst)
    client_corr_in |=> &col_int);
endmodule

bind corr_err_report corr_err_report_chk #(.NUM_FN(NUM_FN)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .ev_rx_err     (ev_rx_err),
  .client_corr_in(client_corr_in),
  .cfg_we        (cfg_we),
  .mgmt_we       (mgmt_we),
  .fn_status     (fn_status),
  .msg_req       (msg_req),
  .msg_ack       (msg_ack)
);

// File: tb/corr_err_report_bench.sv
module corr_err_report_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 4;
  localparam int FW = 2;
  localparam logic [31:0] IMPL = 32'h0000_F1C1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_rx_err = 0, ev_bad_tlp = 0, ev_bad_dllp = 0, ev_phy_flag = 0;
  logic ev_replay_roll = 0, ev_replay_tmo = 0, ev_int_corr = 0, client_corr_in = 0;
  logic [NF-1:0] ev_advisory = '0, ev_hdr_ovf = '0;
  logic cfg_we = 0, mgmt_we = 0, emul_en = 0, msg_ack = 0;
  logic [FW-1:0] cfg_fn = '0, mgmt_fn = '0;
  logic [31:0] cfg_wdata = '0, mgmt_wdata = '0;
  logic [NF*32-1:0] fn_mask = '0;
  logic [NF*32-1:0] fn_status;
  logic msg_req;

  int n_tests = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [31:0] m_sts [NF];
  logic m_req;

  always #(CLK_PERIOD/2) clk = ~clk;

  corr_err_report #(.NUM_FN(NF)) u_corr_err_report (
    .clk(clk), .rst(rst),
    .ev_rx_err(ev_rx_err), .ev_bad_tlp(ev_bad_tlp), .ev_bad_dllp(ev_bad_dllp),
    .ev_phy_flag(ev_phy_flag), .ev_replay_roll(ev_replay_roll),
    .ev_replay_tmo(ev_replay_tmo), .ev_int_corr(ev_int_corr),
    .client_corr_in(client_corr_in), .ev_advisory(ev_advisory),
    .ev_hdr_ovf(ev_hdr_ovf), .cfg_we(cfg_we), .cfg_fn(cfg_fn),
    .cfg_wdata(cfg_wdata), .mgmt_we(mgmt_we), .mgmt_fn(mgmt_fn),
    .mgmt_wdata(mgmt_wdata), .fn_mask(fn_mask), .emul_en(emul_en),
    .fn_status(fn_status), .msg_req(msg_req), .msg_ack(msg_ack)
  );

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual still running at cycle %0d, expected completion", cyc);
      summary();
      $finish;
    end
  end

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clear_stim();
    ev_rx_err = 0; ev_bad_tlp = 0; ev_bad_dllp = 0; ev_phy_flag = 0;
    ev_replay_roll = 0; ev_replay_tmo = 0; ev_int_corr = 0; client_corr_in = 0;
    ev_advisory = '0; ev_hdr_ovf = '0; cfg_we = 0; mgmt_we = 0; msg_ack = 0;
    cfg_wdata = '0; mgmt_wdata = '0;
  endtask

  // reference from the requirements: advance one edge, compare everything
  task automatic cycle(input string tag);
    logic [31:0] lk, st, wr, clr, nxt [NF];
    logic any;
    lk = '0;
    lk[0]  = ev_rx_err;                    // R3
    lk[6]  = ev_bad_tlp;
    lk[7]  = ev_bad_dllp && !ev_phy_flag;  // R11
    lk[8]  = ev_replay_roll;
    lk[12] = ev_replay_tmo;
    lk[14] = ev_int_corr || client_corr_in; // R12
    any = 0;
    for (int f = 0; f < NF; f++) begin
      wr = '0;
      if (cfg_we && cfg_fn == FW'(f))   wr |= cfg_wdata;
      if (mgmt_we && mgmt_fn == FW'(f)) wr |= mgmt_wdata;
      st = lk;
      st[13] = ev_advisory[f];              // R4
      st[15] = ev_hdr_ovf[f];
      if (emul_en) st |= wr;                // R13
      st &= IMPL;                           // R2
      clr = emul_en ? 32'h0 : wr;           // R5 R6
      if ((st & ~m_sts[f] & ~fn_mask[f*32 +: 32]) != 0) any = 1; // R7 R8
      nxt[f] = st | (m_sts[f] & ~clr);      // R10
    end
    m_req = any | (m_req & ~msg_ack);       // R9
    for (int f = 0; f < NF; f++) m_sts[f] = nxt[f];
    @(posedge clk); #1;
    for (int f = 0; f < NF; f++) check32(tag, fn_status[f*32 +: 32], m_sts[f]);
    check32(tag, {31'b0, msg_req}, {31'b0, m_req});
  endtask

  task automatic ack_and_clear_all(input string tag, input bit use_mgmt);
    clear_stim();
    msg_ack = 1;
    cycle("R9 ack");
    clear_stim();
    for (int f = 0; f < NF; f++) begin
      if (use_mgmt) begin mgmt_we = 1; mgmt_fn = FW'(f); mgmt_wdata = '1; end
      else          begin cfg_we = 1;  cfg_fn = FW'(f);  cfg_wdata = '1;  end
      cycle(tag);
      clear_stim();
    end
  endtask

  initial begin
    for (int f = 0; f < NF; f++) m_sts[f] = '0;
    m_req = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    for (int f = 0; f < NF; f++) check32("R1 reset status", fn_status[f*32 +: 32], 32'h0);
    check32("R1 reset request", {31'b0, msg_req}, 32'h0);

    // directed: link event, single request, ack handshake
    ev_rx_err = 1; cycle("R3 rx error");
    clear_stim();
    for (int f = 0; f < NF; f++) check32("R3 bit0 all functions", fn_status[f*32 +: 32], 32'h1);
    check32("R8 one request", {31'b0, msg_req}, 32'h1);
    ev_bad_tlp = 1; cycle("R9 merge");   // merges into pending request
    clear_stim();
    msg_ack = 1; cycle("R9 ack");
    clear_stim();
    check32("R9 request dropped", {31'b0, msg_req}, 32'h0);
    // set beats clear; re-event on set bit gives no request
    ev_rx_err = 1; cfg_we = 1; cfg_fn = 0; cfg_wdata = 32'h1; cycle("R10 collision");
    clear_stim();
    check32("R10 set wins", fn_status[31:0], 32'h41);
    check32("R8 no new request on set bit", {31'b0, msg_req}, 32'h0);
    // write of 0 leaves, write of 1 clears only addressed function
    cfg_we = 1; cfg_fn = 1; cfg_wdata = 32'h0; cycle("R5 zero write");
    clear_stim();
    cfg_we = 1; cfg_fn = 1; cfg_wdata = 32'h40; cycle("R5 clear one bit");
    clear_stim();
    check32("R5 fn1 cleared bit6", fn_status[63:32], 32'h1);
    check32("R5 fn2 untouched", fn_status[95:64], 32'h41);
    ack_and_clear_all("R6 mgmt clear", 1);
    // bad DLLP suppressed by physical flag
    ev_bad_dllp = 1; ev_phy_flag = 1; cycle("R11 suppressed");
    clear_stim();
    check32("R11 bit7 stays clear", fn_status[31:0], 32'h0);
    client_corr_in = 1; cycle("R12 client pin");
    clear_stim();
    check32("R12 bit14", fn_status[127:96], 32'h4000);
    ack_and_clear_all("R5 cfg clear", 0);
    // mask does not gate status, only the request
    fn_mask = '1;
    ev_bad_tlp = 1; cycle("R7 masked event");
    clear_stim();
    check32("R7 status set under mask", fn_status[31:0], 32'h40);
    check32("R7 no request under mask", {31'b0, msg_req}, 32'h0);
    fn_mask = '0;
    ack_and_clear_all("R5 cfg clear", 0);
    // emulation: write all ones sets implemented bits only
    emul_en = 1; cfg_we = 1; cfg_fn = 1; cfg_wdata = '1; cycle("R13 emulation set");
    clear_stim();
    check32("R2 implemented bits only", fn_status[63:32], 32'hF1C1);
    check32("R13 emulated request", {31'b0, msg_req}, 32'h1);
    emul_en = 0;
    ack_and_clear_all("R5 cfg clear", 0);

    // sweep every link-wide event combination with three mask patterns
    for (int c = 0; c < 256; c++) begin
      fn_mask = '0;
      if (c % 3 == 1) fn_mask[31:0] = '1;
      if (c % 3 == 2) fn_mask = '1;
      {client_corr_in, ev_int_corr, ev_replay_tmo, ev_replay_roll,
       ev_phy_flag, ev_bad_dllp, ev_bad_tlp, ev_rx_err} = 8'(c);
      cycle("R3 link sweep");
      ack_and_clear_all("R5 cfg clear", c[0]);
    end
    fn_mask = '0;

    // sweep every per-function event combination
    for (int c = 0; c < 256; c++) begin
      ev_advisory = NF'(c);
      ev_hdr_ovf  = NF'(c >> 4);
      cycle("R4 per-function sweep");
      ack_and_clear_all("R6 mgmt clear", 1);
    end

    // every bit position through each port, set in emulation then cleared
    for (int f = 0; f < NF; f++) begin
      for (int b = 0; b < 32; b++) begin
        for (int p = 0; p < 2; p++) begin
          clear_stim();
          emul_en = 1;
          if (p == 0) begin cfg_we = 1;  cfg_fn = FW'(f);  cfg_wdata = 32'h1 << b; end
          else        begin mgmt_we = 1; mgmt_fn = FW'(f); mgmt_wdata = 32'h1 << b; end
          cycle("R13 bit set sweep");
          clear_stim();
          emul_en = 0;
          if (p == 0) begin mgmt_we = 1; mgmt_fn = FW'(f); mgmt_wdata = 32'h1 << b; end
          else        begin cfg_we = 1;  cfg_fn = FW'(f);  cfg_wdata = 32'h1 << b; end
          cycle("R2 R6 bit clear sweep");
          clear_stim();
          msg_ack = 1;
          cycle("R9 ack");
        end
      end
    end
    clear_stim();
    summary();
    $finish;
  end
endmodule